// File: doc/BRIEF.md
# Radar Test Pattern Sequence Checker

This block checks a stream of 12-bit samples against a fixed pseudo-random test pattern. The pattern is a right-shifting 12-bit linear feedback sequence: each step moves the word down by one bit, and the vacated top bit takes the XOR of the old bits 8, 2, 1 and 0. A sensor in its data test mode fills its sample buffer with this pattern. The block sits on the receive side and tells whether that data arrived intact.

The checker locks onto the stream by itself. While enabled, the first accepted sample sets the expected value, and every later sample is compared with it. A seed input can instead set the expected value directly. Every mismatch raises a sticky error flag and bumps a saturating counter, and a clear input resets both. Because samples travel in pairs, a phase output shows whether an odd number of samples has been taken since enable. The expected-word output can also drive a generator: a consumer that steps it with the same rule rebuilds the pattern.

Top module: `tpat_checker`

## Requirements
- R1: After reset, err_flag is 0, err_count is 0, exp_word is 0 and pair_odd is 0. in_ready is 0 while en is 0.
- R2: Each advance maps the expected word x to {x[0]^x[1]^x[2]^x[8], x[11:1]}, with bit 11 as the MSB.
- R3: Once en is high, the first accepted sample (in_valid and in_ready both high) is not checked. exp_word becomes the advance of that sample.
- R4: Each later accepted sample is compared with exp_word. On a mismatch, err_count rises by one and err_flag is set. exp_word then advances from its own value, whether or not the sample matched.
- R5: While en is 0, in_ready is 0 and the samples on the input have no effect on err_count, err_flag or exp_word. pair_odd is 0. Enabling again makes the checker lock onto the stream anew.
- R6: When en and seed_load are both high, exp_word takes seed_val on the next edge and checking starts from the next sample. in_ready is 0 in that cycle, so a sample offered then is not taken.
- R7: A seed of zero, whether it comes through seed_load or from the first sample, counts as one error and sets err_flag.
- R8: err_count saturates at its all-ones value.
- R9: err_flag stays set until clr. clr zeroes err_count and err_flag on the next edge, and it wins over an error in the same cycle.
- R10: With en high and seed_load low, in_ready stays high. Back-to-back samples are each accepted and checked, one per cycle.
- R11: pair_odd toggles on every accepted sample and shows 1 after an odd number of accepted samples since enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Test-mode enable |
| clr | input | 1 | Clears the error flag and the error count |
| seed_load | input | 1 | Load seed_val as the next expected word |
| seed_val | input | 12 | Seed value |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_data | input | 12 | Received sample |
| err_flag | output | 1 | Sticky mismatch flag |
| err_count | output | CNT_W | Saturating mismatch count |
| exp_word | output | 12 | Expected value of the next sample |
| pair_odd | output | 1 | Odd number of samples accepted since enable |

## Verification
The bench feeds in a clean pattern from a non-zero start. This shows that the feedback taps are correct and that lock-on raises no false error. It injects one corrupted sample inside a clean run, which shows that the count rises by exactly one and that the expected sequence keeps going past the bad word. It drives garbage while disabled and seeds with zero, which separates ignored input from a real error. A long run of wrong samples, and a clear that lands on an error, test saturation and clear priority.

// File: rtl/tpat_checker.sv
module tpat_checker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             seed_load,
  input  logic [11:0]      seed_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [11:0]      in_data,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count,
  output logic [11:0]      exp_word,
  output logic             pair_odd
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [11:0] adv(input logic [11:0] x);
    return {x[0] ^ x[1] ^ x[2] ^ x[8], x[11:1]};
  endfunction

  logic synced;

  assign in_ready = en & ~seed_load;

  wire        acc      = in_valid & in_ready;
  wire        seeding  = (en & seed_load) | (acc & ~synced);
  wire [11:0] seed_src = seed_load ? seed_val : in_data;
  wire        bad      = (seeding & (seed_src == 12'd0)) |
                         (acc & synced & (in_data != exp_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced   <= 1'b0;
      exp_word <= '0;
      pair_odd <= 1'b0;
    end else if (!en) begin
      synced   <= 1'b0;
      pair_odd <= 1'b0;
    end else if (seed_load) begin
      exp_word <= seed_val;
      synced   <= 1'b1;
    end else if (acc) begin
      exp_word <= synced ? adv(exp_word) : adv(in_data);
      synced   <= 1'b1;
      pair_odd <= ~pair_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count <= '0;
      err_flag  <= 1'b0;
    end else if (clr) begin
      err_count <= '0;
      err_flag  <= 1'b0;
    end else if (bad) begin
      err_flag <= 1'b1;
      if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end
  end

  p_hold_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(err_count) && $stable(exp_word) && $stable(err_flag)));

  p_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && seed_load) |=> (exp_word == $past(seed_val)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !clr) |=> (err_count == CNT_MAX));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> err_flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_count == '0 && !err_flag));

  p_ready_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !in_ready);
endmodule

// File: tb/tpat_checker_test.sv
module tpat_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0, en = 0, clr = 0, seed_load = 0, in_valid = 0;
  logic [11:0] seed_val = 0, in_data = 0;
  logic in_ready, err_flag, pair_odd;
  logic [CW-1:0] err_count;
  logic [11:0] exp_word;
  int checks = 0, errors = 0;
  logic [11:0] e;
  int cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpat_checker #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .seed_load(seed_load),
    .seed_val(seed_val), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .err_flag(err_flag), .err_count(err_count),
    .exp_word(exp_word), .pair_odd(pair_odd));

  function automatic logic [11:0] nx(input logic [11:0] x);
    logic fb;
    fb = x[0] ^ x[1] ^ x[2] ^ x[8];
    return (x >> 1) | ({11'd0, fb} << 11);
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [11:0] d, input string tag);
    in_valid = 1; in_data = d;
    #1 chk({tag, " ready"}, in_ready, 1);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 flag", err_flag, 0);
    chk("R1 count", err_count, 0);
    chk("R1 exp", exp_word, 0);
    chk("R1 pair", pair_odd, 0);
    chk("R1 ready", in_ready, 0);
  endtask

  task automatic t_sync_run;
    en = 1;
    e = 12'h5A3;
    push(e, "R3");
    e = nx(e);
    chk("R3 exp after lock", exp_word, e);
    chk("R3 no check on first", err_count, 0);
    chk("R11 pair after 1", pair_odd, 1);
    for (int i = 0; i < 8; i++) begin
      push(e, "R10");
      e = nx(e);
      chk("R2 exp step", exp_word, e);
    end
    chk("R4 clean count", err_count, 0);
    chk("R4 clean flag", err_flag, 0);
    chk("R11 pair after 9", pair_odd, 1);
    push(e, "R10"); e = nx(e);
    chk("R11 pair after 10", pair_odd, 0);
  endtask

  task automatic t_mismatch;
    push(e ^ 12'h001, "R4");
    e = nx(e);
    chk("R4 count after bad", err_count, 1);
    chk("R4 flag after bad", err_flag, 1);
    chk("R4 exp continues", exp_word, e);
    push(e, "R4"); e = nx(e);
    chk("R4 count after good", err_count, 1);
    chk("R9 flag sticky", err_flag, 1);
  endtask

  task automatic t_disabled;
    en = 0;
    tick;
    chk("R5 pair cleared", pair_odd, 0);
    in_valid = 1;
    for (int i = 0; i < 4; i++) begin
      in_data = 12'hF0F ^ i[11:0];
      #1 chk("R5 ready low", in_ready, 0);
      tick;
    end
    in_valid = 0;
    chk("R5 count held", err_count, 1);
    chk("R5 exp held", exp_word, e);
    en = 1;
    e = 12'h3C7;
    push(e, "R5"); e = nx(e);
    chk("R5 relock exp", exp_word, e);
    chk("R5 relock no error", err_count, 1);
  endtask

  task automatic t_clear;
    clr = 1; tick; clr = 0;
    chk("R9 clear count", err_count, 0);
    chk("R9 clear flag", err_flag, 0);
    clr = 1;
    push(~e, "R9"); e = nx(e);
    clr = 0;
    chk("R9 clear wins count", err_count, 0);
    chk("R9 clear wins flag", err_flag, 0);
  endtask

  task automatic t_seed;
    seed_load = 1; seed_val = 12'h123; in_valid = 1; in_data = 12'h000;
    #1 chk("R6 ready low on seed", in_ready, 0);
    tick;
    seed_load = 0; in_valid = 0;
    chk("R6 exp seeded", exp_word, 12'h123);
    chk("R6 offered sample ignored", err_count, 0);
    e = 12'h123;
    push(e, "R6"); e = nx(e);
    chk("R6 checked from seed", err_count, 0);
    chk("R6 exp step", exp_word, e);
  endtask

  task automatic t_zero;
    seed_load = 1; seed_val = 0; tick; seed_load = 0;
    chk("R7 zero seed count", err_count, 1);
    chk("R7 zero seed flag", err_flag, 1);
    clr = 1; tick; clr = 0;
    en = 0; tick; en = 1;
    push(12'h000, "R7");
    chk("R7 zero sample seed", err_count, 1);
    chk("R7 zero sample flag", err_flag, 1);
  endtask

  task automatic t_sat;
    clr = 1; tick; clr = 0;
    e = exp_word;
    for (int i = 0; i < 20; i++) begin
      push(e ^ 12'h800, "R8");
      e = nx(e);
    end
    chk("R8 saturated", err_count, (1 << CW) - 1);
    chk("R8 flag", err_flag, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    tick; rst_n = 1; tick;
    t_reset;
    t_sync_run;
    t_mismatch;
    t_disabled;
    t_clear;
    t_seed;
    t_zero;
    t_sat;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule